// File: doc/BRIEF.md
# UART FIFO Interrupt Generator

This block raises the transmit and receive interrupt requests of a UART whose buffering runs in one of two modes. A mode bit picks the mode. In single-register mode, each interrupt follows the state of the holding register on its side. In FIFO mode, each interrupt is driven by the occupancy count that the FIFO reports. The receive side also has a timeout path. It fires when characters sit in the receive FIFO and no new character has arrived for three character times.

The block contains no storage for data. The UART core supplies the occupancy counts, the holding-register flags, a strobe for each received character, a strobe for each FIFO read, a baud-rate bit tick and the frame length in bits. The block has no stream interface: every pin is a plain control or status level, or a one-cycle strobe. There is no back-pressure to handle. Both interrupt outputs are registered, so each one reflects its inputs one clock after they are sampled.

Top module: `uart_irq_gen`

## Requirements
- R1: While `rst_n` is low, both `tx_irq` and `rx_irq` are 0.
- R2: With `fifo_en`=0, `tx_irq` equals the inverse of `tx_hold_full` sampled one clock earlier, whatever `tx_level` is.
- R3: With `fifo_en`=0, `rx_irq` equals `rx_hold_valid` sampled one clock earlier, whatever `rx_level` is.
- R4: With `fifo_en`=1, `tx_irq` is 1 one clock after `tx_level` <= DEPTH/2 (half or more of the FIFO is free). It is 0 one clock after `tx_level` > DEPTH/2.
- R5: With `fifo_en`=1, `rx_irq` goes to 1 one clock after `rx_level` >= DEPTH/2.
- R6: With `fifo_en`=1, once `rx_irq` is 1 it stays 1 while `rx_level` is nonzero, even if the level drops below DEPTH/2 or reads occur. It returns to 0 one clock after `rx_level` = 0.
- R7: With `fifo_en`=1 and `rx_level` nonzero, a timer counts `bit_tick` pulses. When it reaches 3×`frame_bits` with no strobe on `rx_push` or `rx_pop`, `rx_irq` goes to 1 one clock after the tick that completes the count.
- R8: A pulse on `rx_push` or on `rx_pop` restarts the timeout count from zero.
- R9: After only 3×`frame_bits`−1 ticks, the timeout has not fired and `rx_irq` stays 0.
- R10: The timer does not advance while `rx_level` = 0. Ticks received while the FIFO is empty do not count toward a later timeout.
- R11: The timeout length follows `frame_bits`. A changed frame length moves the firing point to 3× the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 = FIFO mode, 0 = single-register mode |
| tx_level | input | CNT_W | Transmit FIFO occupancy |
| rx_level | input | CNT_W | Receive FIFO occupancy |
| tx_hold_full | input | 1 | Transmit holding register holds a character |
| rx_hold_valid | input | 1 | Receive holding register holds a valid character |
| rx_push | input | 1 | One-cycle strobe for each received character |
| rx_pop | input | 1 | One-cycle strobe for each receive FIFO read |
| bit_tick | input | 1 | One-cycle strobe per serial bit time |
| frame_bits | input | FRAME_W | Bits per character frame (at least 1) |
| tx_irq | output | 1 | Transmit interrupt level |
| rx_irq | output | 1 | Receive interrupt level |

## Verification
The bench builds the block with DEPTH=8, which puts the half-way threshold at an occupancy of 4. This lets the bench reach both sides of each threshold with small level values. It keeps FRAME_W=4 and runs frame lengths of 3 and 5, so the timeout windows are 9 and 15 ticks. These short windows make it practical to probe the tick just before firing, the firing tick itself, and a restart in the middle of a window.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  // Buffering mode selected by the enable bit.
  typedef enum logic {
    MODE_HOLD = 1'b0,
    MODE_FIFO = 1'b1
  } buf_mode_e;
endpackage

// File: rtl/uart_irq_tx.sv
module uart_irq_tx
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  buf_mode_e        mode,
  input  logic [CNT_W-1:0] tx_level,
  input  logic             tx_hold_full,
  output logic             tx_irq
);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(DEPTH / 2);

  logic tx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q <= 1'b0;
    end else if (mode == MODE_FIFO) begin
      tx_q <= (tx_level <= HALF_C);
    end else begin
      tx_q <= !tx_hold_full;
    end
  end

  assign tx_irq = tx_q;

  // R4: FIFO-mode transmit request tracks the free-space threshold
  assert_tx_fifo_thresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FIFO) |=> (tx_irq == ($past(tx_level) <= HALF_C)));

  // R2: single-register mode follows the holding register
  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD) |=> (tx_irq == !$past(tx_hold_full)));
endmodule

// File: rtl/uart_rx_timer.sv
module uart_rx_timer
  import uart_irq_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int FRAME_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  buf_mode_e          mode,
  input  logic [CNT_W-1:0]   rx_level,
  input  logic               rx_push,
  input  logic               rx_pop,
  input  logic               bit_tick,
  input  logic [FRAME_W-1:0] frame_bits,
  output logic               timeout
);
  localparam int LIM_W = FRAME_W + 2;

  logic [LIM_W-1:0] limit;
  logic [LIM_W-1:0] cnt_q;
  logic             idle;

  // three frames' worth of bit times: f + 2f
  assign limit = {2'b00, frame_bits} + {1'b0, frame_bits, 1'b0};
  assign idle  = (mode != MODE_FIFO) || (rx_level == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (idle || rx_push || rx_pop) begin
      cnt_q <= '0;
    end else if (bit_tick && (cnt_q < limit)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign timeout = !idle && (cnt_q >= limit);

  // R8: any arrival or read restarts the window
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push || rx_pop) |=> (cnt_q == '0));

  // R10: an empty FIFO holds the timer at zero
  assert_empty_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/uart_irq_rx.sv
module uart_irq_rx
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  buf_mode_e        mode,
  input  logic [CNT_W-1:0] rx_level,
  input  logic             rx_hold_valid,
  input  logic             timeout,
  output logic             rx_irq
);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(DEPTH / 2);

  logic rx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q <= 1'b0;
    end else if (mode == MODE_HOLD) begin
      rx_q <= rx_hold_valid;
    end else if (rx_level == '0) begin
      rx_q <= 1'b0;
    end else if ((rx_level >= HALF_C) || timeout) begin
      rx_q <= 1'b1;
    end
  end

  assign rx_irq = rx_q;

  // R6: sticky in FIFO mode until drained
  assert_rx_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FIFO && rx_irq && rx_level != '0) |=> rx_irq);

  // R6: drained FIFO clears the request
  assert_rx_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FIFO && rx_level == '0) |=> !rx_irq);

  // R5/R7: a rise in FIFO mode needs the threshold or the timeout
  assert_rx_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_irq) && $past(mode) == MODE_FIFO) |->
      (($past(rx_level) >= HALF_C) || $past(timeout)));
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
  import uart_irq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int FRAME_W = 4,
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_en,
  input  logic [CNT_W-1:0]   tx_level,
  input  logic [CNT_W-1:0]   rx_level,
  input  logic               tx_hold_full,
  input  logic               rx_hold_valid,
  input  logic               rx_push,
  input  logic               rx_pop,
  input  logic               bit_tick,
  input  logic [FRAME_W-1:0] frame_bits,
  output logic               tx_irq,
  output logic               rx_irq
);
  buf_mode_e mode;
  logic      timeout;

  assign mode = fifo_en ? MODE_FIFO : MODE_HOLD;

  uart_irq_tx #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .tx_level     (tx_level),
    .tx_hold_full (tx_hold_full),
    .tx_irq       (tx_irq)
  );

  uart_rx_timer #(.CNT_W(CNT_W), .FRAME_W(FRAME_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .rx_level   (rx_level),
    .rx_push    (rx_push),
    .rx_pop     (rx_pop),
    .bit_tick   (bit_tick),
    .frame_bits (frame_bits),
    .timeout    (timeout)
  );

  uart_irq_rx #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode          (mode),
    .rx_level      (rx_level),
    .rx_hold_valid (rx_hold_valid),
    .timeout       (timeout),
    .rx_irq        (rx_irq)
  );

  // R1: both requests quiet while reset is held
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (!tx_irq && !rx_irq));
endmodule

// File: tb/uart_irq_gen_test.sv
module uart_irq_gen_test;
  localparam int DEPTH   = 8;
  localparam int FRAME_W = 4;
  localparam int CNT_W   = $clog2(DEPTH + 1);

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               fifo_en = 1'b0;
  logic [CNT_W-1:0]   tx_level = '0;
  logic [CNT_W-1:0]   rx_level = '0;
  logic               tx_hold_full = 1'b0;
  logic               rx_hold_valid = 1'b0;
  logic               rx_push = 1'b0;
  logic               rx_pop = 1'b0;
  logic               bit_tick = 1'b0;
  logic [FRAME_W-1:0] frame_bits = 4'd3;
  logic               tx_irq;
  logic               rx_irq;

  int applied = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [3:0] exp_q[$];   // {check_tx, check_rx, exp_tx, exp_rx}
  string      tag_q[$];

  always #10 clk = ~clk;

  uart_irq_gen #(.DEPTH(DEPTH), .FRAME_W(FRAME_W)) uut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_hold_full(tx_hold_full), .rx_hold_valid(rx_hold_valid),
    .rx_push(rx_push), .rx_pop(rx_pop), .bit_tick(bit_tick),
    .frame_bits(frame_bits), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  // Driver: one clock edge, then queue what the outputs must show.
  task automatic step(input bit ct, input bit cr, input bit et, input bit er,
                      input string tag);
    @(posedge clk);
    #1;
    if (ct || cr) begin
      exp_q.push_back({ct, cr, et, er});
      tag_q.push_back(tag);
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, "");
  endtask

  task automatic ticks(input int n);
    bit_tick = 1'b1;
    idle(n);
    bit_tick = 1'b0;
  endtask

  task automatic pulse_push();
    rx_push = 1'b1; idle(1); rx_push = 1'b0;
  endtask

  // Monitor: compares queued expectations away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (e[3]) begin
          applied++;
          if (tx_irq !== e[1]) begin
            miscompares++;
            $display("FAIL %s tx_irq actual=%b expected=%b", t, tx_irq, e[1]);
          end
        end
        if (e[2]) begin
          applied++;
          if (rx_irq !== e[0]) begin
            miscompares++;
            $display("FAIL %s rx_irq actual=%b expected=%b", t, rx_irq, e[0]);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    step(1, 1, 0, 0, "R1");
    step(1, 1, 0, 0, "R1");
    rst_n = 1'b1;

    // R2 / R3: single-register mode, FIFO levels ignored
    tx_level = '0; rx_level = 4'd8;
    tx_hold_full = 1'b0; step(1, 1, 1, 0, "R2");
    tx_hold_full = 1'b1; step(1, 0, 0, 0, "R2");
    rx_hold_valid = 1'b1; step(0, 1, 0, 1, "R3");
    rx_hold_valid = 1'b0; step(0, 1, 0, 0, "R3");

    // R4: FIFO-mode transmit threshold (half = 4)
    rx_level = '0;
    fifo_en = 1'b1;
    tx_level = 4'd0; step(1, 0, 1, 0, "R4");
    tx_level = 4'd4; step(1, 0, 1, 0, "R4");
    tx_level = 4'd5; step(1, 0, 0, 0, "R4");
    tx_level = 4'd8; step(1, 0, 0, 0, "R4");

    // R5 / R6: receive threshold and stickiness
    rx_level = 4'd3; step(0, 1, 0, 0, "R5");
    rx_level = 4'd4; step(0, 1, 0, 1, "R5");
    rx_level = 4'd2; step(0, 1, 0, 1, "R6");
    rx_pop = 1'b1; rx_level = 4'd1; step(0, 1, 0, 1, "R6");
    rx_pop = 1'b0;
    rx_level = 4'd0; step(0, 1, 0, 0, "R6");

    // R9 / R8 / R7: timeout with 3-bit frames (window 9)
    frame_bits = 4'd3;
    rx_level = 4'd1; pulse_push();
    ticks(8);
    step(0, 1, 0, 0, "R9");
    pulse_push();
    ticks(8);
    step(0, 1, 0, 0, "R8");
    ticks(1);
    step(0, 1, 0, 1, "R7");
    rx_pop = 1'b1; step(0, 1, 0, 1, "R6");
    rx_pop = 1'b0;
    rx_level = 4'd0; step(0, 1, 0, 0, "R6");

    // R10: ticks while empty do not count
    ticks(20);
    rx_level = 4'd1;
    ticks(8);
    step(0, 1, 0, 0, "R10");
    rx_level = 4'd0; idle(1);

    // R11: 5-bit frames, window 15
    frame_bits = 4'd5;
    rx_level = 4'd2; pulse_push();
    ticks(14);
    step(0, 1, 0, 0, "R11");
    ticks(1);
    step(0, 1, 0, 1, "R11");

    // R3: leaving FIFO mode hands control back to the holding flag
    fifo_en = 1'b0; rx_hold_valid = 1'b0;
    step(0, 1, 0, 0, "R3");

    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule